// File: doc/BRIEF.md
# Board Panel Register Block

This block is a small memory-mapped register file for board-level status and display. A processor-side bus writes and reads it with single-cycle strobes. It holds an 8-bit LED bar value and an eight-character ASCII text buffer. The text buffer can be loaded in two ways. One register takes a 32-bit word and turns it in hardware into eight uppercase hexadecimal digits. A row of per-position registers each store one character. The LED value and the whole text buffer are brought out as pins, so downstream logic can drive a panel or a debug display.

The block also holds a general-purpose output byte and the registers for a bit-banged I2C port: two output-enable bits, a clock/data output pair and a one-bit bus select. A write of a parameterised magic value to the soft-reset register raises a one-cycle system reset request. A one-cycle display strobe marks every LED or text update, so a consumer only refreshes on change.

Register offsets (the low 20 address bits):

| Offset | Access | Use |
|---|---|---|
| 0x00000 | R | switches |
| 0x00020 | R/W | LED bar |
| 0x00410 | W | word-to-hex |
| 0x00418 + 8·i | W | character i |
| 0x00500 | W | soft reset |
| 0x00A00 | R/W | GP output |
| 0x00B00 | R | I2C input |
| 0x00B08 | R/W | I2C output-enable |
| 0x00B10 | R/W | I2C clock/data output |
| 0x00B18 | R/W | I2C select |

Top module: `brd_panel_regs`

## Requirements
- R1: Only address bits [19:0] select a register. Accesses that differ only in bits [31:20] reach the same register.
- R2: A write to offset 0x00020 stores bits [7:0] of the data in the LED register. The upper data bits are dropped. The value appears on `led_o` one cycle after the write edge and reads back zero-extended at the same offset.
- R3: A write to offset 0x00410 replaces all eight characters with the uppercase ASCII hex digits of the 32-bit data. Digits 0-9 map to 0x30-0x39 and A-F map to 0x41-0x46. Character 0 takes bits [31:28] and character 7 takes bits [3:0].
- R4: A write to offset 0x418 + 8·i, for i from 0 to 7, stores data bits [7:0] as character i and leaves the other characters unchanged. An offset inside that range that is not a multiple of 8 from 0x418 is unmapped. Character i appears on `disp_text_o[8i+7:8i]`.
- R5: While reset is asserted:
  - every character is 0x20 (space);
  - the LED, GP output, output-enable, select and `bus_rdata` are zero;
  - `i2c_scl_o` and `i2c_sda_o` are 1;
  - `disp_chg_o` and `sys_rst_req_o` are low.
- R6: The GP output register (0x00A00) keeps 8 data bits. The I2C output-enable register (0x00B08) keeps bits [1:0]. The I2C select register (0x00B18) keeps bit 0. Each reads back zero-extended and drives its output pin.
- R7: A write of RST_MAGIC (default 0x42, compared over all 32 bits) to offset 0x00500 raises `sys_rst_req_o` for exactly one cycle. Any other value, or the magic value at any other offset, raises nothing.
- R8: A read of offset 0x00000 returns zero.
- R9: A write to 0x00B10 sets `i2c_scl_o` from data bit 1 and `i2c_sda_o` from data bit 0. Reading 0x00B10 returns {scl, sda} in bits [1:0]. Reading 0x00B00 returns the stored clock bit in bit 1 and the live `i2c_sda_i` level in bit 0. Writes to 0x00B00 have no effect.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register and raise no strobe.
- R11: `disp_chg_o` pulses for one cycle after any LED, word or character write, and for no other write.
- R12: `bus_rdata` is registered. It takes the addressed value one cycle after a cycle with `bus_rd` high and holds it while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address; bits [19:0] decoded |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| led_o | output | LED_W | LED bar value |
| disp_text_o | output | 8·(DATA_W/4) | Text buffer, character i in byte i |
| disp_chg_o | output | 1 | One-cycle display update strobe |
| sys_rst_req_o | output | 1 | One-cycle soft reset request |
| gp_out_o | output | GP_W | General-purpose output byte |
| i2c_oe_o | output | 2 | I2C output enables |
| i2c_scl_o | output | 1 | I2C clock output level |
| i2c_sda_o | output | 1 | I2C data output level |
| i2c_sel_o | output | 1 | I2C bus select |
| i2c_sda_i | input | 1 | Live I2C data line |

## Verification
A wrong decode shows up in two ways. A write can land in the wrong register, which appears on that register's output pin one cycle later. A read can return a neighbouring value in `bus_rdata` one cycle after the read strobe. A corrupt character or a wrong hex digit appears in the matching byte of `disp_text_o` on the cycle after the write. A stuck or stretched control strobe shows on `disp_chg_o` or `sys_rst_req_o` within two cycles of the triggering write.

// File: rtl/brd_panel_pkg.sv
package brd_panel_pkg;

    // Width of the decoded byte offset
    localparam int OFFS_W = 20;
    // Character registers are spaced 2**CHAR_STRIDE_LG bytes apart
    localparam int CHAR_STRIDE_LG = 3;
    localparam logic [7:0] CHAR_SPACE = 8'h20;

    localparam logic [OFFS_W-1:0] OFF_SWITCH  = 20'h00000;
    localparam logic [OFFS_W-1:0] OFF_LED     = 20'h00020;
    localparam logic [OFFS_W-1:0] OFF_WORD    = 20'h00410;
    localparam logic [OFFS_W-1:0] OFF_CHAR0   = 20'h00418;
    localparam logic [OFFS_W-1:0] OFF_SOFTRST = 20'h00500;
    localparam logic [OFFS_W-1:0] OFF_GPOUT   = 20'h00A00;
    localparam logic [OFFS_W-1:0] OFF_I2C_IN  = 20'h00B00;
    localparam logic [OFFS_W-1:0] OFF_I2C_OE  = 20'h00B08;
    localparam logic [OFFS_W-1:0] OFF_I2C_OUT = 20'h00B10;
    localparam logic [OFFS_W-1:0] OFF_I2C_SEL = 20'h00B18;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SWITCH,
        SEL_LED,
        SEL_WORD,
        SEL_CHAR,
        SEL_SOFTRST,
        SEL_GPOUT,
        SEL_I2C_IN,
        SEL_I2C_OE,
        SEL_I2C_OUT,
        SEL_I2C_SEL
    } reg_sel_e;

    // Uppercase ASCII hex digit for one nibble
    function automatic logic [7:0] hex_ascii(input logic [3:0] nib);
        return (nib < 4'd10) ? (8'h30 + {4'h0, nib}) : (8'h37 + {4'h0, nib});
    endfunction

endpackage

// File: rtl/brd_panel_decode.sv
module brd_panel_decode
    import brd_panel_pkg::*;
#(
    parameter int NCHAR = 8,
    parameter int IDX_W = 3
) (
    input  logic [OFFS_W-1:0] offset,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  char_idx
);

    localparam logic [OFFS_W-1:0] CHAR_SPAN = OFFS_W'(NCHAR << CHAR_STRIDE_LG);

    logic [OFFS_W-1:0] rel;
    logic              in_char_row;

    assign rel         = offset - OFF_CHAR0;
    assign in_char_row = (offset >= OFF_CHAR0) && (rel < CHAR_SPAN)
                         && (rel[CHAR_STRIDE_LG-1:0] == '0);
    assign char_idx    = rel[CHAR_STRIDE_LG +: IDX_W];

    always_comb begin
        unique case (offset)
            OFF_SWITCH:  sel = SEL_SWITCH;
            OFF_LED:     sel = SEL_LED;
            OFF_WORD:    sel = SEL_WORD;
            OFF_SOFTRST: sel = SEL_SOFTRST;
            OFF_GPOUT:   sel = SEL_GPOUT;
            OFF_I2C_IN:  sel = SEL_I2C_IN;
            OFF_I2C_OE:  sel = SEL_I2C_OE;
            OFF_I2C_OUT: sel = SEL_I2C_OUT;
            OFF_I2C_SEL: sel = SEL_I2C_SEL;
            default:     sel = in_char_row ? SEL_CHAR : SEL_NONE;
        endcase
    end

endmodule

// File: rtl/brd_panel_textbuf.sv
module brd_panel_textbuf
    import brd_panel_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NCHAR  = 8,
    parameter int IDX_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 word_we,
    input  logic                 char_we,
    input  logic [IDX_W-1:0]     char_idx,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NCHAR*8-1:0]   text_o
);

    // Character g holds nibble g counted from the most significant end
    for (genvar g = 0; g < NCHAR; g++) begin : g_char
        logic [7:0] ch_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ch_q <= CHAR_SPACE;
            end else if (word_we) begin
                ch_q <= hex_ascii(wdata[DATA_W-1-4*g -: 4]);
            end else if (char_we && (char_idx == IDX_W'(g))) begin
                ch_q <= wdata[7:0];
            end
        end

        assign text_o[8*g +: 8] = ch_q;
    end

endmodule

// File: rtl/brd_panel_ctrl.sv
module brd_panel_ctrl
    import brd_panel_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          LED_W     = 8,
    parameter int          GP_W      = 8,
    parameter logic [31:0] RST_MAGIC = 32'h42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [LED_W-1:0]  led_o,
    output logic [GP_W-1:0]   gp_o,
    output logic [1:0]        oe_o,
    output logic              sel_o,
    output logic              scl_o,
    output logic              sda_o,
    output logic              chg_o,
    output logic              rst_req_o
);

    logic disp_hit;
    assign disp_hit = (sel == SEL_LED) || (sel == SEL_WORD) || (sel == SEL_CHAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            led_o     <= '0;
            gp_o      <= '0;
            oe_o      <= '0;
            sel_o     <= 1'b0;
            scl_o     <= 1'b1;
            sda_o     <= 1'b1;
            chg_o     <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            chg_o     <= wr && disp_hit;
            rst_req_o <= wr && (sel == SEL_SOFTRST) && (wdata == DATA_W'(RST_MAGIC));
            if (wr) begin
                unique case (sel)
                    SEL_LED:     led_o <= wdata[LED_W-1:0];
                    SEL_GPOUT:   gp_o  <= wdata[GP_W-1:0];
                    SEL_I2C_OE:  oe_o  <= wdata[1:0];
                    SEL_I2C_SEL: sel_o <= wdata[0];
                    SEL_I2C_OUT: begin
                        scl_o <= wdata[1];
                        sda_o <= wdata[0];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/brd_panel_regs.sv
module brd_panel_regs
    import brd_panel_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          LED_W     = 8,
    parameter int          GP_W      = 8,
    parameter logic [31:0] RST_MAGIC = 32'h42,
    localparam int         NCHAR     = DATA_W / 4,
    localparam int         IDX_W     = $clog2(NCHAR)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [LED_W-1:0]    led_o,
    output logic [NCHAR*8-1:0]  disp_text_o,
    output logic                disp_chg_o,
    output logic                sys_rst_req_o,
    output logic [GP_W-1:0]     gp_out_o,
    output logic [1:0]          i2c_oe_o,
    output logic                i2c_scl_o,
    output logic                i2c_sda_o,
    output logic                i2c_sel_o,
    input  logic                i2c_sda_i
);

    reg_sel_e          sel;
    logic [IDX_W-1:0]  char_idx;
    logic [DATA_W-1:0] rd_val;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFFS_W];

    brd_panel_decode #(.NCHAR(NCHAR), .IDX_W(IDX_W)) u_decode (
        .offset   (bus_addr[OFFS_W-1:0]),
        .sel      (sel),
        .char_idx (char_idx)
    );

    brd_panel_textbuf #(.DATA_W(DATA_W), .NCHAR(NCHAR), .IDX_W(IDX_W)) u_textbuf (
        .clk      (clk),
        .rst      (rst),
        .word_we  (bus_wr && (sel == SEL_WORD)),
        .char_we  (bus_wr && (sel == SEL_CHAR)),
        .char_idx (char_idx),
        .wdata    (bus_wdata),
        .text_o   (disp_text_o)
    );

    brd_panel_ctrl #(
        .DATA_W(DATA_W), .LED_W(LED_W), .GP_W(GP_W), .RST_MAGIC(RST_MAGIC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .sel       (sel),
        .wdata     (bus_wdata),
        .led_o     (led_o),
        .gp_o      (gp_out_o),
        .oe_o      (i2c_oe_o),
        .sel_o     (i2c_sel_o),
        .scl_o     (i2c_scl_o),
        .sda_o     (i2c_sda_o),
        .chg_o     (disp_chg_o),
        .rst_req_o (sys_rst_req_o)
    );

    always_comb begin
        unique case (sel)
            SEL_LED:     rd_val = DATA_W'(led_o);
            SEL_GPOUT:   rd_val = DATA_W'(gp_out_o);
            SEL_I2C_IN:  rd_val = DATA_W'({i2c_scl_o, i2c_sda_i});
            SEL_I2C_OE:  rd_val = DATA_W'(i2c_oe_o);
            SEL_I2C_OUT: rd_val = DATA_W'({i2c_scl_o, i2c_sda_o});
            SEL_I2C_SEL: rd_val = DATA_W'(i2c_sel_o);
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end

endmodule

// File: rtl/brd_panel_chk.sv
module brd_panel_chk
    import brd_panel_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          LED_W     = 8,
    parameter int          TEXT_W    = 64,
    parameter logic [31:0] RST_MAGIC = 32'h42
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LED_W-1:0]  led_o,
    input logic [TEXT_W-1:0] disp_text_o,
    input logic              disp_chg_o,
    input logic              sys_rst_req_o
);

    logic armed_q;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (rst || !armed_q)
        sys_rst_req_o |=> !sys_rst_req_o);

    assert_rst_cause_R7: assert property (@(posedge clk) disable iff (rst || !armed_q)
        sys_rst_req_o |-> ($past(bus_wr) && ($past(bus_wdata) == DATA_W'(RST_MAGIC))
                           && ($past(bus_addr[OFFS_W-1:0]) == OFF_SOFTRST)));

    assert_led_load_R2: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ($past(bus_wr) && ($past(bus_addr[OFFS_W-1:0]) == OFF_LED))
        |-> (led_o == $past(bus_wdata[LED_W-1:0])));

    assert_led_hold_R2: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$past(bus_wr) |-> $stable(led_o));

    assert_chg_cause_R11: assert property (@(posedge clk) disable iff (rst || !armed_q)
        disp_chg_o |-> $past(bus_wr));

    assert_text_strobe_R11: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$stable(disp_text_o) |-> disp_chg_o);

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

bind brd_panel_regs brd_panel_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W),
    .TEXT_W(NCHAR*8), .RST_MAGIC(RST_MAGIC)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .led_o         (led_o),
    .disp_text_o   (disp_text_o),
    .disp_chg_o    (disp_chg_o),
    .sys_rst_req_o (sys_rst_req_o)
);

// File: tb/test_brd_panel_regs.sv
`timescale 1ns/1ps
module test_brd_panel_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  led_o, gp_out_o;
    logic [63:0] disp_text_o;
    logic        disp_chg_o, sys_rst_req_o;
    logic [1:0]  i2c_oe_o;
    logic        i2c_scl_o, i2c_sda_o, i2c_sel_o;
    logic        i2c_sda_i = 1'b0;

    int nvec = 0, nerr = 0;
    bit done = 0;
    logic last_chg, last_rst;
    logic [7:0] model [8];

    always #2.5 clk = ~clk;

    brd_panel_regs i_brd_panel_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .led_o(led_o), .disp_text_o(disp_text_o), .disp_chg_o(disp_chg_o),
        .sys_rst_req_o(sys_rst_req_o), .gp_out_o(gp_out_o), .i2c_oe_o(i2c_oe_o),
        .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o), .i2c_sel_o(i2c_sel_o),
        .i2c_sda_i(i2c_sda_i)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write; samples the strobes on the cycle after the edge
    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        last_chg = disp_chg_o;
        last_rst = sys_rst_req_o;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    function automatic logic [63:0] model_text();
        logic [63:0] t;
        for (int i = 0; i < 8; i++) t[8*i +: 8] = model[i];
        return t;
    endfunction

    function automatic logic [7:0] hexch(input int n);
        return (n < 10) ? 8'(48 + n) : 8'(65 + n - 10);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] x;
        for (int i = 0; i < 8; i++) model[i] = 8'h20;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5 reset state
        chk("R5 text", disp_text_o, 64'h2020202020202020);
        chk("R5 led", {56'h0, led_o}, 64'h0);
        chk("R5 gp", {56'h0, gp_out_o}, 64'h0);
        chk("R5 i2c", {59'h0, i2c_oe_o, i2c_sel_o, i2c_scl_o, i2c_sda_o}, 64'h3);
        chk("R5 strobes", {62'h0, disp_chg_o, sys_rst_req_o}, 64'h0);
        chk("R5 rdata", {32'h0, bus_rdata}, 64'h0);

        // R8 switches read zero even after a write attempt
        wr(32'h0000_0000, 32'hFFFF_FFFF);
        rd(32'h0000_0000, 32'h0, "R8 switch");

        // R2 LED sweep with junk in upper data bits; R11 strobe
        for (int v = 0; v < 256; v += 17) begin
            wr(32'h0000_0020, {24'hABCDEF, 8'(v)});
            chk("R2 led_o", {56'h0, led_o}, 64'(v));
            chk("R11 chg led", {63'h0, last_chg}, 64'h1);
            rd(32'h0000_0020, 32'(v), "R2 led read");
        end

        // R1 upper address bits ignored
        wr(32'hFFF0_0020, 32'h5A);
        chk("R1 led alias write", {56'h0, led_o}, 64'h5A);
        rd(32'h1230_0020, 32'h5A, "R1 led alias read");

        // R3 word-to-hex over fixed and pseudo-random words
        x = 32'h1357_9BDF;
        for (int k = 0; k < 40; k++) begin
            logic [31:0] w;
            if (k == 0) w = 32'h0;
            else if (k == 1) w = 32'hFFFF_FFFF;
            else if (k == 2) w = 32'h0123_ABCD;
            else begin x = x * 32'd1664525 + 32'd1013904223; w = x; end
            wr(32'h0000_0410, w);
            for (int i = 0; i < 8; i++) model[i] = hexch(int'((w >> (28 - 4*i)) & 32'hF));
            chk("R3 hex text", disp_text_o, model_text());
            chk("R11 chg word", {63'h0, last_chg}, 64'h1);
        end

        // R4 per-position characters, with alias bits
        for (int p = 0; p < 8; p++) begin
            wr(32'h0ab0_0418 + 32'(8*p), 32'hFFFF_FF00 | 32'(8'h61 + p));
            model[p] = 8'(8'h61 + p);
            chk("R4 char write", disp_text_o, model_text());
            chk("R11 chg char", {63'h0, last_chg}, 64'h1);
        end
        wr(32'h0000_041C, 32'h21);
        chk("R4 misaligned no effect", disp_text_o, model_text());
        chk("R10 misaligned no strobe", {63'h0, last_chg}, 64'h0);
        wr(32'h0000_0458, 32'h21);
        chk("R4 past last char no effect", disp_text_o, model_text());

        // R6 GP output, enable and select widths
        for (int v = 0; v < 256; v += 5) begin
            wr(32'h0000_0A00, 32'hFFFF_FF00 | 32'(v));
            chk("R6 gp pin", {56'h0, gp_out_o}, 64'(v));
            chk("R11 no chg gp", {63'h0, last_chg}, 64'h0);
        end
        rd(32'h0000_0A00, 32'hFF, "R6 gp read");
        wr(32'h0000_0B08, 32'hFFFF_FFFE);
        chk("R6 oe pin", {62'h0, i2c_oe_o}, 64'h2);
        rd(32'h0000_0B08, 32'h2, "R6 oe read");
        wr(32'h0000_0B18, 32'hFFFF_FFFE);
        chk("R6 sel low", {63'h0, i2c_sel_o}, 64'h0);
        wr(32'h0000_0B18, 32'h3);
        rd(32'h0000_0B18, 32'h1, "R6 sel read");

        // R7 soft reset request
        wr(32'h0000_0500, 32'h42);
        chk("R7 magic pulse", {63'h0, last_rst}, 64'h1);
        @(negedge clk);
        chk("R7 pulse one cycle", {63'h0, sys_rst_req_o}, 64'h0);
        wr(32'h0000_0500, 32'h142);
        chk("R7 wrong value", {63'h0, last_rst}, 64'h0);
        wr(32'h0000_0020, 32'h42);
        chk("R7 wrong offset", {63'h0, last_rst}, 64'h0);

        // R9 I2C loopback and live data line
        wr(32'h0000_0B10, 32'h2);
        chk("R9 pins", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h2);
        i2c_sda_i = 1'b1;
        rd(32'h0000_0B00, 32'h3, "R9 in scl1 sda1");
        i2c_sda_i = 1'b0;
        rd(32'h0000_0B00, 32'h2, "R9 in scl1 sda0");
        wr(32'h0000_0B10, 32'h1);
        i2c_sda_i = 1'b1;
        rd(32'h0000_0B00, 32'h1, "R9 in scl0 sda1");
        rd(32'h0000_0B10, 32'h1, "R9 out read");
        wr(32'h0000_0B00, 32'hFF);
        chk("R9 in write ignored", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h1);

        // R10 unmapped offsets
        rd(32'h0000_0B10, 32'h1, "R12 nonzero before");
        rd(32'h0007_FFF0, 32'h0, "R10 unmapped read");
        wr(32'h0007_FFF0, 32'hFFFF_FFFF);
        chk("R10 unmapped led", {56'h0, led_o}, 64'h42);
        chk("R10 unmapped text", disp_text_o, model_text());
        chk("R10 unmapped gp", {56'h0, gp_out_o}, 64'hFF);
        chk("R10 unmapped strobe", {63'h0, last_chg}, 64'h0);

        // R12 read data holds without a read strobe
        rd(32'h0000_0020, 32'h42, "R12 read led");
        @(negedge clk); bus_addr = 32'h0000_0A00;
        @(negedge clk);
        chk("R12 rdata hold", {32'h0, bus_rdata}, 64'h42);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule